// File: doc/BRIEF.md
# DRAM Page Miss Detector

This block tells a DRAM controller whether a new access can reuse the page that is already open or must first close it and open another. At every qualified access start it compares the incoming row address and bank select with those saved from the previous access. It also reports a miss if the column counter has carried past the end of the page since the last start. The first access after reset always misses, because no page is open yet.

The miss pin can point either way. In output mode the block drives the flag itself and asserts the pin's drive enable. In input mode the drive enable is low, and the flag it reports is the one the system supplies, for example a processor that has its own page comparator. The flag is meaningful only while both the address strobe and the chip select are high. Outside that window it reads zero. For the whole qualified window it keeps the value decided in the start cycle.

Top module: `pageMissDetector`

## Requirements
- R1: At an output-mode access start, the miss flag is 1 when the row address differs from the row saved at the previous access start.
- R2: At an output-mode access start, the miss flag is 1 when the bank select differs from the bank saved at the previous access start.
- R3: A column carry pulse seen in any cycle between two access starts makes the miss flag 1 at the next start. The carry is forgotten once that start has passed.
- R4: At an output-mode access start with the same row and bank as the previous access and no pending carry, the miss flag is 0.
- R5: The first access start after reset reports a miss whatever the address.
- R6: The miss flag is 0 in every cycle in which the address strobe and the chip select are not both 1.
- R7: With external mode = 1, the miss flag equals the system's miss input during the qualified window, and the drive enable is 0. With external mode = 0, the drive enable is 1.
- R8: An access start is the first cycle in which strobe and select are both 1 after a cycle in which they were not. The flag's value in that cycle is held for every later cycle of the same qualified window.
- R9: Row and bank are saved at every access start, in either mode. A later output-mode access compares against them.
- R10: A carry pulse in the same cycle as an access start does not affect that access. It counts as pending for the following access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrStrobe | input | 1 | Address strobe, active high |
| chipSel | input | 1 | Chip select, active high |
| rowAddr | input | ROW_W | Row address of the access |
| bankSel | input | BANK_W | Bank select of the access |
| colCarry | input | 1 | Carry-out pulse from the column counter |
| extMode | input | 1 | 1: the system supplies the miss decision |
| missIn | input | 1 | Miss decision supplied by the system |
| missOut | output | 1 | Page-miss flag |
| missOe | output | 1 | Drive enable for the miss pin |

## Verification
The hardest case to reach is the timing of the carry relative to an access start. A carry must be shown to be held across idle cycles, to be consumed by exactly one start, and to be deferred when it lands on a start. The bench places carry pulses in an idle gap, in the hold cycle, and exactly on the start cycle. It then runs a repeat access to the same address, where only the carry can cause a miss. Exhaustive sweeps over every pair of consecutive (row, bank) values cover the comparison paths. Accesses in external mode are inserted to show that the saved address still follows them.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
  typedef struct packed {
    logic qualified;   // strobe and select both high
    logic startPulse;  // first qualified cycle of an access
    logic firstAccess; // no page opened since reset
  } pmdStrobes_t;
endpackage

// File: rtl/pmdFieldCmp.sv
module pmdFieldCmp #(
  parameter int W = 4
) (
  input  logic [W-1:0] fieldA,
  input  logic [W-1:0] fieldB,
  output logic         differs
);
  logic [W-1:0] bitDiff;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bitDiff[i] = fieldA[i] ^ fieldB[i];
  end
  assign differs = |bitDiff;
endmodule

// File: rtl/pmdControl.sv
module pmdControl
  import pmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrStrobe,
  input  logic        chipSel,
  output pmdStrobes_t strobes
);
  logic qualPrev;
  logic pageOpen;
  logic qualNow;

  assign qualNow = addrStrobe & chipSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qualPrev <= 1'b0;
      pageOpen <= 1'b0;
    end else begin
      qualPrev <= qualNow;
      if (qualNow && !qualPrev) pageOpen <= 1'b1;
    end
  end

  always_comb begin
    strobes.qualified   = qualNow;
    strobes.startPulse  = qualNow & ~qualPrev;
    strobes.firstAccess = ~pageOpen;
  end

  // R8: a start is never followed directly by another start
  p_single_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startPulse |=> !strobes.startPulse);
  // R5: once any start has happened, a page stays open
  p_page_open_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startPulse |=> !strobes.firstAccess);
endmodule

// File: rtl/pmdDatapath.sv
module pmdDatapath
  import pmd_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pmdStrobes_t       strobes,
  input  logic [ROW_W-1:0]  rowAddr,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              colCarry,
  output logic              localMiss
);
  logic [ROW_W-1:0]  savedRow;
  logic [BANK_W-1:0] savedBank;
  logic              crossPending;
  logic              heldMiss;
  logic              rowDiff;
  logic              bankDiff;
  logic              freshMiss;

  pmdFieldCmp #(.W(ROW_W)) u_rowCmp (
    .fieldA(rowAddr), .fieldB(savedRow), .differs(rowDiff));
  pmdFieldCmp #(.W(BANK_W)) u_bankCmp (
    .fieldA(bankSel), .fieldB(savedBank), .differs(bankDiff));

  assign freshMiss = strobes.firstAccess | rowDiff | bankDiff | crossPending;
  assign localMiss = strobes.startPulse ? freshMiss : heldMiss;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedRow     <= '0;
      savedBank    <= '0;
      crossPending <= 1'b0;
      heldMiss     <= 1'b0;
    end else begin
      if (strobes.startPulse) begin
        savedRow  <= rowAddr;
        savedBank <= bankSel;
        heldMiss  <= freshMiss;
        crossPending <= colCarry;         // same-cycle carry is deferred
      end else if (colCarry) begin
        crossPending <= 1'b1;
      end
    end
  end

  // R9: row and bank captured at every start
  p_capture_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startPulse |=> (savedRow == $past(rowAddr) && savedBank == $past(bankSel)));
  // R3: a carry is consumed by the start that follows it
  p_cross_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.startPulse && !colCarry) |=> !crossPending);
  // R10: a carry on the start cycle survives for the next access
  p_cross_defer_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.startPulse && colCarry) |=> crossPending);
  // R3: a pending carry forces a miss at the start
  p_cross_miss_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.startPulse && crossPending) |-> localMiss);
endmodule

// File: rtl/pageMissDetector.sv
module pageMissDetector
  import pmd_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrStrobe,
  input  logic              chipSel,
  input  logic [ROW_W-1:0]  rowAddr,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              colCarry,
  input  logic              extMode,
  input  logic              missIn,
  output logic              missOut,
  output logic              missOe
);
  pmdStrobes_t strobes;
  logic        localMiss;

  pmdControl u_ctl (
    .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe), .chipSel(chipSel),
    .strobes(strobes));

  pmdDatapath #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rowAddr(rowAddr),
    .bankSel(bankSel), .colCarry(colCarry), .localMiss(localMiss));

  always_comb begin
    missOe  = ~extMode;
    missOut = 1'b0;
    if (strobes.qualified) missOut = extMode ? missIn : localMiss;
  end

  // R6: no flag outside the qualified window
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(addrStrobe && chipSel) |-> !missOut);
  // R5: first access after reset misses in output mode
  p_first_miss_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.startPulse && strobes.firstAccess && !extMode) |-> missOut);
  // R8: flag held through the window in output mode
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (addrStrobe && chipSel && !extMode) |=>
      ((addrStrobe && chipSel && !extMode) |-> $stable(missOut)));
  // R7: external mode passes the system decision through
  p_ext_pass_r7: assert property (@(posedge clk) disable iff (!rstN)
    (addrStrobe && chipSel && extMode) |-> (missOut == missIn && !missOe));
endmodule

// File: tb/pageMissDetector_bench.sv
module pageMissDetector_bench;
  localparam int RW = 3;
  localparam int BW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrStrobe = 1'b0, chipSel = 1'b0, colCarry = 1'b0;
  logic extMode = 1'b0, missIn = 1'b0;
  logic [RW-1:0] rowAddr = '0;
  logic [BW-1:0] bankSel = '0;
  logic missOut, missOe;

  int total = 0, bad = 0;
  bit refOpen = 0, refCross = 0;
  logic [RW-1:0] refRow = '0;
  logic [BW-1:0] refBank = '0;

  always #10 clk = ~clk; // 50 MHz

  pageMissDetector #(.ROW_W(RW), .BANK_W(BW)) u_pageMissDetector (
    .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe), .chipSel(chipSel),
    .rowAddr(rowAddr), .bankSel(bankSel), .colCarry(colCarry),
    .extMode(extMode), .missIn(missIn), .missOut(missOut), .missOe(missOe));

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // one access: start cycle, one hold cycle, one idle cycle
  task automatic access(input logic [RW-1:0] r, input logic [BW-1:0] b,
                        input bit ext, input bit sysMiss,
                        input bit carryStart, input bit carryHold, input string req);
    logic exp;
    @(negedge clk);
    rowAddr = r; bankSel = b; extMode = ext; missIn = sysMiss;
    addrStrobe = 1'b1; chipSel = 1'b1; colCarry = carryStart;
    if (ext) exp = sysMiss;
    else exp = !refOpen || (r != refRow) || (b != refBank) || refCross;
    #2;
    chk(req, missOut, exp);
    chk("R7", missOe, !ext);
    refOpen = 1; refRow = r; refBank = b; refCross = carryStart;
    @(negedge clk);
    colCarry = carryHold;
    if (carryHold) refCross = 1;
    #2;
    chk("R8", missOut, exp);
    @(negedge clk);
    addrStrobe = 1'b0; colCarry = 1'b0;
    #2;
    chk("R6", missOut, 1'b0);
  endtask

  task automatic idleCarry();
    @(negedge clk); colCarry = 1'b1; refCross = 1;
    @(negedge clk); colCarry = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        #2;
        chk("R6", missOut, 1'b0);
        chk("R7", missOe, 1'b1);
        rstN = 1'b1;
        access(3'd5, 2'd1, 0, 0, 0, 0, "R5");
        access(3'd5, 2'd1, 0, 0, 0, 0, "R4");
        // strobe without select stays quiet
        @(negedge clk); addrStrobe = 1'b1; chipSel = 1'b0; #2;
        chk("R6", missOut, 1'b0);
        @(negedge clk); addrStrobe = 1'b0;
        // exhaustive pairs in output mode
        for (int a = 0; a < 32; a++)
          for (int c = 0; c < 32; c++) begin
            access(a[4:2], a[1:0], 0, 0, 0, 0, "R1 R2");
            access(c[4:2], c[1:0], 0, 0, 0, 0,
                   (a[4:2] != c[4:2]) ? "R1" : (a[1:0] != c[1:0]) ? "R2" : "R4");
          end
        // carry in idle gap, then repeat address
        idleCarry();
        access(3'd2, 2'd3, 0, 0, 0, 0, "R3");
        access(3'd2, 2'd3, 0, 0, 0, 0, "R3");
        // carry in hold cycle
        access(3'd2, 2'd3, 0, 0, 0, 1, "R4");
        access(3'd2, 2'd3, 0, 0, 0, 0, "R3");
        access(3'd2, 2'd3, 0, 0, 0, 0, "R3");
        // carry on the start cycle is deferred
        access(3'd2, 2'd3, 0, 0, 1, 0, "R10");
        access(3'd2, 2'd3, 0, 0, 0, 0, "R10");
        access(3'd2, 2'd3, 0, 0, 0, 0, "R10");
        // external mode passes missIn; address still captured
        for (int k = 0; k < 8; k++) begin
          access(k[2:0], 2'(k), 1, k[0], 0, 0, "R7");
          access(k[2:0], 2'(k), 0, 0, 0, 0, "R9");
        end
        access(3'd6, 2'd0, 1, 0, 0, 0, "R7");
        access(3'd6, 2'd0, 0, 0, 0, 0, "R9");
        access(3'd1, 2'd0, 1, 1, 0, 0, "R7");
        access(3'd6, 2'd0, 0, 0, 0, 0, "R9");
      end
      begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule